// File: doc/BRIEF.md
# Serial Transmitter with Freeze-on-Disable

This block is the sending half of an asynchronous serial port. Software writes bytes into an eight-entry queue. Each byte is sent on a single output line as a ten-bit frame: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames. A 16-bit divisor sets the bit period to `divisor + 1` clock cycles.

The block reports four conditions:

- a busy flag, set while anything is queued or being sent;
- a queue-full flag;
- a sticky overflow flag, set when a write is lost;
- a level interrupt that asks for more data once the queue has run dry.

The defining behaviour is what happens when the enable input is dropped in the middle of a frame. The frame is neither aborted nor completed. The shifter and the bit timer stop where they are, the line holds its present level, and busy stays high. Only after enable returns does the frame continue from the same point, finish, and let busy fall. Software must therefore wait for busy to clear before it turns the port off.

Top module: `uart_tx_hold`

## Requirements
- R1: After synchronous reset, the line is high and busy, full, interrupt and overflow are all low.
- R2: Each frame consists of one low start bit, then data bits 0 through 7 in that order, then one high stop bit. Every bit lasts exactly `divisor + 1` clock cycles.
- R3: The queue stores 8 bytes. The full flag rises once 8 bytes are waiting, and queued bytes are sent in the order they were written.
- R4: A write made while the queue is full is discarded and sets the overflow flag. The flag stays set until reset.
- R5: Busy is high whenever the queue is non-empty or a frame is being sent. It falls at the end of the stop bit of the last byte.
- R6: While enable is low, the line level does not change. A frame that has already started keeps busy high for as long as enable stays low.
- R7: When enable returns, a frozen frame continues from the bit and the position within the bit where it stopped, and then completes.
- R8: The interrupt source is set when the last queued byte moves into the shifter and the queue is left empty. It is cleared by any accepted write.
- R9: The interrupt output is the source ANDed with the interrupt-enable input. With interrupt-enable low, the output is low.
- R10: While enable is low and no frame is in progress, queued bytes stay in the queue and no start bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable; low freezes the shifter |
| div | input | 16 | Bit period minus one, in clock cycles |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | Queue non-empty or frame in progress |
| full | output | 1 | Queue holds 8 bytes |
| irq | output | 1 | Queue-empty interrupt, level |
| ovf | output | 1 | Sticky lost-write flag |

## Verification
A bit index or bit timer that has gone wrong shows up on `txd` within one bit period: the sample taken at the middle of a bit then reads the wrong level or falls in a neighbouring bit. Freezing is checked by watching the line and busy across a long disabled stretch. Resuming is checked by sampling the rest of the frame on the original bit grid, shifted by exactly the number of disabled cycles. Faults in the queue pointers or the full count appear as reordered or missing bytes in a burst of nine writes, or as a full flag at the wrong depth. A misplaced interrupt source shows on `irq` directly after a frame or a write.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } shift_t;

    function automatic logic frame_level(input shift_t s);
        logic [IDX_W-1:0] k;
        k = s.idx - IDX_W'(1);
        if (!s.active)                            return 1'b1;
        else if (s.idx == '0)                     return 1'b0;
        else if (s.idx == IDX_W'(FRAME_BITS - 1)) return 1'b1;
        else                                      return s.data[k[$clog2(DATA_W)-1:0]];
    endfunction
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         last
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;

    assign head  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign last  = (count == CW'(1));

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (tick)       cnt <= '0;
        else if (run)        cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    output logic              load,
    output logic              active,
    output logic              txd
);
    shift_t s;

    assign load   = en && !s.active && avail;
    assign active = s.active;
    assign txd    = frame_level(s);

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= '{active: 1'b0, idx: '0, data: '0};
        end else if (load) begin
            s <= '{active: 1'b1, idx: '0, data: din};
        end else if (s.active && tick) begin
            if (s.idx == IDX_W'(FRAME_BITS - 1)) s.active <= 1'b0;
            else                                  s.idx    <= s.idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import utx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    output logic              txd,
    output logic              busy,
    output logic              full,
    output logic              irq,
    output logic              ovf
);
    logic              push, load, q_empty, q_last, active, tick;
    logic [DATA_W-1:0] head;
    logic              pend;

    assign push = wr_valid && !full;

    utx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_data(wr_data),
        .pop(load), .head(head), .full(full), .empty(q_empty), .last(q_last)
    );

    utx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .restart(load), .run(en && active),
        .div(div), .tick(tick)
    );

    utx_shifter u_shift (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .avail(!q_empty),
        .din(head), .load(load), .active(active), .txd(txd)
    );

    assign busy = active || !q_empty;
    assign irq  = pend && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (wr_valid && full) ovf <= 1'b1;
            if (push)                  pend <= 1'b0;
            else if (load && q_last)   pend <= 1'b1;
        end
    end
endmodule

// File: rtl/utx_chk.sv
module utx_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic wr_valid,
    input logic irq_en,
    input logic txd,
    input logic busy,
    input logic full,
    input logic irq,
    input logic ovf
);
    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
    // R5
    full_busy_chk: assert property (@(posedge clk) disable iff (rst) full |-> busy);
    // R6
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst) (!en && busy) |=> busy);
    // R6
    hold_line_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(txd));
    // R4
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst) (wr_valid && full) |=> ovf);
    // R4
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
    // R8
    write_clear_chk: assert property (@(posedge clk) disable iff (rst) (wr_valid && !full) |=> !irq);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst) irq |-> irq_en);
endmodule

bind uart_tx_hold utx_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .irq_en(irq_en),
    .txd(txd), .busy(busy), .full(full), .irq(irq), .ovf(ovf)
);

// File: tb/sim_uart_tx_hold.sv
module sim_uart_tx_hold;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] div = 16'd3;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        irq_en = 1'b0;
    logic        txd, busy, full, irq, ovf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_tx_hold u0 (
        .clk(clk), .rst(rst), .en(en), .div(div), .wr_valid(wr_valid),
        .wr_data(wr_data), .irq_en(irq_en), .txd(txd), .busy(busy),
        .full(full), .irq(irq), .ovf(ovf)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Receive one frame sampled at bit centres; checks R2 and the data value.
    task automatic recv_frame(input logic [7:0] exp, input string req);
        int per = int'(div) + 1;
        logic [7:0] got;
        wait_start();
        repeat (per / 2) @(negedge clk);
        check("R2", "start bit", txd, 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (per) @(negedge clk);
            got[i] = txd;
        end
        check(req, "data byte", got, exp);
        repeat (per) @(negedge clk);
        check("R2", "stop bit", txd, 1'b1);
    endtask

    task automatic test_reset();
        check("R1", "txd", txd, 1'b1);
        check("R1", "busy", busy, 1'b0);
        check("R1", "full", full, 1'b0);
        check("R1", "irq", irq, 1'b0);
        check("R1", "ovf", ovf, 1'b0);
    endtask

    task automatic test_frames();
        logic [7:0] pat [3] = '{8'hA5, 8'h01, 8'h80};
        logic [15:0] dv [3] = '{16'd3, 16'd0, 16'd5};
        en = 1'b1;
        irq_en = 1'b1;
        for (int t = 0; t < 3; t++) begin
            int per;
            div = dv[t];
            per = int'(div) + 1;
            write_byte(pat[t]);
            check("R8", "irq cleared by write", irq, 1'b0);
            check("R5", "busy after write", busy, 1'b1);
            recv_frame(pat[t], "R2");
            repeat (per - per / 2) @(negedge clk);
            check("R5", "busy after stop", busy, 1'b0);
            check("R8", "irq after drain", irq, 1'b1);
        end
        irq_en = 1'b0;
        #1;
        check("R9", "irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R9", "irq unmasked", irq, 1'b1);
    endtask

    task automatic test_full();
        en = 1'b0;
        div = 16'd2;
        for (int i = 0; i < 8; i++) write_byte(8'h10 + 8'(i));
        check("R3", "full at 8", full, 1'b1);
        check("R4", "ovf before drop", ovf, 1'b0);
        write_byte(8'hEE);
        check("R4", "ovf after drop", ovf, 1'b1);
        repeat (20) @(negedge clk);
        check("R10", "line idle while disabled", txd, 1'b1);
        check("R10", "queue kept", full, 1'b1);
        check("R5", "busy with queued data", busy, 1'b1);
        en = 1'b1;
        for (int i = 0; i < 8; i++) recv_frame(8'h10 + 8'(i), "R3");
        repeat (4) @(negedge clk);
        check("R4", "dropped byte not sent", busy, 1'b0);
        check("R4", "ovf sticky", ovf, 1'b1);
    endtask

    task automatic test_freeze();
        int per;
        logic lvl;
        logic ok = 1'b1;
        logic [7:0] got;
        en = 1'b1;
        div = 16'd3;
        per = 4;
        write_byte(8'h3C);
        wait_start();
        repeat (per / 2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            repeat (per) @(negedge clk);
            got[i] = txd;
        end
        lvl = txd;
        en = 1'b0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (txd !== lvl || busy !== 1'b1) ok = 1'b0;
        end
        check("R6", "frozen line and busy", ok, 1'b1);
        en = 1'b1;
        for (int i = 5; i < 8; i++) begin
            repeat (per) @(negedge clk);
            got[i] = txd;
        end
        check("R7", "resumed byte", got, 8'h3C);
        repeat (per) @(negedge clk);
        check("R7", "stop after resume", txd, 1'b1);
        repeat (per - per / 2) @(negedge clk);
        check("R7", "idle after resume", busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_frames();
        test_full();
        test_freeze();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule